// File: doc/BRIEF.md
# Pseudo-Channel Burst Striping Scheduler

This block schedules memory transactions onto a set of pseudo-channels. Each accepted transaction carries a byte count, a read/write flag, a pacing interval and an identifier. The block cuts the transaction into fixed-size bursts and deals the bursts out across the pseudo-channels in rotation. The rotation pointer is global: it persists from one transaction to the next, and reads and writes share it.

Time is an integer cycle counter that starts at zero when reset is released. For every pseudo-channel the block holds the cycle at which that channel becomes free, and the direction of the last burst it served. From these it works out a start and a finish cycle for each burst, reporting one burst per cycle on a commit output. A burst pays a turnaround penalty when its channel last served the opposite direction. The transaction retires with a one-cycle done pulse that carries its identifier. The pulse is timed by the latest burst finish, or by the end of the fixed overhead if that is later.

A valid/ready handshake admits one transaction at a time. Service time, turnaround penalty and fixed overhead come from configuration inputs that are held static while a transaction is in flight. The pacing interval comes with each request.

Top module: `pc_stripe_sched`

## Requirements
- R1: The burst count of a transaction is its working size divided by BURST_BYTES (256 by default), rounded up. A working size of zero gives zero bursts, and such a transaction still retires. The block raises cmtValid for exactly that many consecutive cycles.
- R2: Burst k of a transaction (k counted from 0) goes to channel (P + k) mod NUM_PCS, where P is the global pointer (NUM_PCS is 8 by default). After the transaction, P has advanced by the burst count, modulo NUM_PCS. P is 0 after reset and is shared by reads and writes.
- R3: The working size is reqBytes. For a read (reqWrite=0) whose reqBytes is zero, the working size is reqOrigBytes instead. reqWrite=1 marks a write.
- R4: A burst's start cycle is the later of its issue cycle and its channel's free cycle, plus any turnaround penalty. Its finish cycle is the start cycle plus cfgServiceCycles, and this finish becomes the channel's new free cycle. Reads and writes update the same per-channel record.
- R5: The turnaround penalty cfgSwitchPenalty is added only when the channel has served at least one earlier burst since reset and that burst's direction differs from the current one. When cfgSwitchPenalty is 0, a change of direction costs no extra cycles.
- R6: Let T0 be the cycle-counter value at the accepting clock edge. Burst k is issued at cycle T0 + cfgOverhead + (k+1) * reqPace, so with reqPace = 0 every burst issues at T0 + cfgOverhead.
- R7: doneValid is high for one cycle with doneId equal to the transaction's reqId. That cycle is the one in which the counter equals the maximum of three values: T0 + cfgOverhead, the latest burst finish, and T0 + 1 + burst count.
- R8: reqReady is high only while the block is idle: after reset, and from the cycle after a done pulse until the next transaction is accepted. After reset doneValid and cmtValid are low.
- R9: Commits of a transaction start in the cycle after acceptance. cmtValid is never high together with reqReady or doneValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transaction offered |
| reqReady | output | 1 | Block idle, transaction accepted when reqValid is high |
| reqId | input | ID_W | Transaction identifier |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBytes | input | BYTES_W | Transaction byte count |
| reqOrigBytes | input | BYTES_W | Original request size, used by reads with reqBytes = 0 |
| reqPace | input | CYC_W | Cycles between successive burst issues |
| cfgServiceCycles | input | CYC_W | Cycles one burst occupies its channel |
| cfgSwitchPenalty | input | CYC_W | Read/write turnaround penalty in cycles |
| cfgOverhead | input | CYC_W | Fixed cycles before the first issue |
| cmtValid | output | 1 | A burst is committed this cycle |
| cmtPc | output | PC_W | Channel of the committed burst |
| cmtStart | output | TIME_W | Start cycle of the committed burst |
| cmtFinish | output | TIME_W | Finish cycle of the committed burst |
| doneValid | output | 1 | Transaction retires this cycle |
| doneId | output | ID_W | Identifier of the retiring transaction |

## Verification
The transactions are chained so that the global pointer wraps and passes back over channels that bursts have just used. This separates a pointer that persists from one that restarts, and an exact modulo from an off-by-one wrap. Reads and writes alternate on the same channels, so a shared free-time record with a penalty on direction change can be told apart from separate per-direction records or a penalty charged on every burst. Some transactions stack more bursts than there are channels. Others use nonzero pacing, and one is a zero-length write, so that completion bounded by the last finish can be told apart from completion bounded by the fixed overhead or by the commit walk. A zero-size read sized from its original request, and a rerun with the penalty cleared, cover the remaining sizing and penalty paths.

// File: rtl/pc_stripe_pkg.sv
package pc_stripe_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new transaction
    logic step;   // commit one burst
  } stripe_ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHUNK = 2'd1,
    ST_WAIT  = 2'd2
  } stripe_state_t;

endpackage

// File: rtl/pc_stripe_ctrl.sv
module pc_stripe_ctrl
  import pc_stripe_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         zeroChunks,
  input  logic         lastChunk,
  input  logic         timeUp,
  output logic         reqReady,
  output logic         cmtValid,
  output logic         doneValid,
  output stripe_ctrl_t ctrl
);

  stripe_state_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD    = stateQ;
    ctrl      = '0;
    reqReady  = 1'b0;
    cmtValid  = 1'b0;
    doneValid = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctrl.load = 1'b1;
          stateD    = zeroChunks ? ST_WAIT : ST_CHUNK;
        end
      end
      ST_CHUNK: begin
        ctrl.step = 1'b1;
        cmtValid  = 1'b1;
        if (lastChunk) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (timeUp) begin
          doneValid = 1'b1;
          stateD    = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/pc_stripe_dp.sv
module pc_stripe_dp
  import pc_stripe_pkg::*;
#(
  parameter int NUM_PCS     = 8,
  parameter int BURST_BYTES = 256,
  parameter int BYTES_W     = 20,
  parameter int ID_W        = 8,
  parameter int CYC_W       = 8,
  parameter int TIME_W      = 32,
  localparam int PC_W       = (NUM_PCS > 1) ? $clog2(NUM_PCS) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  stripe_ctrl_t       ctrl,
  input  logic [ID_W-1:0]    reqId,
  input  logic               reqWrite,
  input  logic [BYTES_W-1:0] reqBytes,
  input  logic [BYTES_W-1:0] reqOrigBytes,
  input  logic [CYC_W-1:0]   reqPace,
  input  logic [CYC_W-1:0]   cfgServiceCycles,
  input  logic [CYC_W-1:0]   cfgSwitchPenalty,
  input  logic [CYC_W-1:0]   cfgOverhead,
  output logic               zeroChunks,
  output logic               lastChunk,
  output logic               timeUp,
  output logic [PC_W-1:0]    cmtPc,
  output logic [TIME_W-1:0]  cmtStart,
  output logic [TIME_W-1:0]  cmtFinish,
  output logic [ID_W-1:0]    doneId
);

  localparam int BURST_SH = $clog2(BURST_BYTES);
  localparam int CNT_W    = BYTES_W - BURST_SH + 1;

  // request sizing
  logic [BYTES_W-1:0] workBytes;
  logic [BYTES_W:0]   roundedBytes;
  logic [CNT_W-1:0]   reqChunks;

  assign workBytes    = (!reqWrite && reqBytes == '0) ? reqOrigBytes : reqBytes;
  assign roundedBytes = {1'b0, workBytes} + (BYTES_W+1)'(BURST_BYTES - 1);
  assign reqChunks    = roundedBytes[BYTES_W:BURST_SH];
  assign zeroChunks   = (reqChunks == '0);

  // transaction state
  logic [TIME_W-1:0] nowQ;
  logic [PC_W-1:0]   ptrQ;
  logic [CNT_W-1:0]  leftQ;
  logic [TIME_W-1:0] issueQ;
  logic [TIME_W-1:0] maxFinQ;
  logic              dirQ;
  logic [ID_W-1:0]   idQ;
  logic [CYC_W-1:0]  svcQ;
  logic [CYC_W-1:0]  penQ;
  logic [CYC_W-1:0]  paceQ;

  // per-channel state
  logic [TIME_W-1:0] availQ   [NUM_PCS];
  logic              usedQ    [NUM_PCS];
  logic              lastDirQ [NUM_PCS];

  logic [TIME_W-1:0] chanAvail;
  logic              switchHit;
  logic [TIME_W-1:0] readyT;
  logic [TIME_W-1:0] startT;
  logic [TIME_W-1:0] finishT;
  logic [PC_W-1:0]   ptrNext;

  assign chanAvail = availQ[ptrQ];
  assign switchHit = usedQ[ptrQ] && (lastDirQ[ptrQ] != dirQ);
  assign readyT    = (issueQ > chanAvail) ? issueQ : chanAvail;
  assign startT    = readyT + (switchHit ? TIME_W'(penQ) : '0);
  assign finishT   = startT + TIME_W'(svcQ);
  assign ptrNext   = (ptrQ == PC_W'(NUM_PCS - 1)) ? '0 : ptrQ + 1'b1;

  assign lastChunk = (leftQ == CNT_W'(1));
  assign timeUp    = (nowQ >= maxFinQ);
  assign cmtPc     = ptrQ;
  assign cmtStart  = startT;
  assign cmtFinish = finishT;
  assign doneId    = idQ;

  // free-running time base
  always_ff @(posedge clk) begin
    if (!rst_n) nowQ <= '0;
    else        nowQ <= nowQ + 1'b1;
  end

  // global rotation pointer
  always_ff @(posedge clk) begin
    if (!rst_n)         ptrQ <= '0;
    else if (ctrl.step) ptrQ <= ptrNext;
  end

  // per-transaction registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      leftQ   <= '0;
      issueQ  <= '0;
      maxFinQ <= '0;
      dirQ    <= 1'b0;
      idQ     <= '0;
      svcQ    <= '0;
      penQ    <= '0;
      paceQ   <= '0;
    end else if (ctrl.load) begin
      leftQ   <= reqChunks;
      issueQ  <= nowQ + TIME_W'(cfgOverhead) + TIME_W'(reqPace);
      maxFinQ <= nowQ + TIME_W'(cfgOverhead);
      dirQ    <= reqWrite;
      idQ     <= reqId;
      svcQ    <= cfgServiceCycles;
      penQ    <= cfgSwitchPenalty;
      paceQ   <= reqPace;
    end else if (ctrl.step) begin
      leftQ  <= leftQ - 1'b1;
      issueQ <= issueQ + TIME_W'(paceQ);
      if (finishT > maxFinQ) maxFinQ <= finishT;
    end
  end

  // channel records, one register set per pseudo-channel
  for (genvar g = 0; g < NUM_PCS; g++) begin : gChan
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        availQ[g]   <= '0;
        usedQ[g]    <= 1'b0;
        lastDirQ[g] <= 1'b0;
      end else if (ctrl.step && ptrQ == PC_W'(g)) begin
        availQ[g]   <= finishT;
        usedQ[g]    <= 1'b1;
        lastDirQ[g] <= dirQ;
      end
    end
  end

endmodule

// File: rtl/pc_stripe_sched.sv
module pc_stripe_sched
  import pc_stripe_pkg::*;
#(
  parameter int NUM_PCS     = 8,
  parameter int BURST_BYTES = 256,
  parameter int BYTES_W     = 20,
  parameter int ID_W        = 8,
  parameter int CYC_W       = 8,
  parameter int TIME_W      = 32,
  localparam int PC_W       = (NUM_PCS > 1) ? $clog2(NUM_PCS) : 1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ID_W-1:0]    reqId,
  input  logic               reqWrite,
  input  logic [BYTES_W-1:0] reqBytes,
  input  logic [BYTES_W-1:0] reqOrigBytes,
  input  logic [CYC_W-1:0]   reqPace,
  input  logic [CYC_W-1:0]   cfgServiceCycles,
  input  logic [CYC_W-1:0]   cfgSwitchPenalty,
  input  logic [CYC_W-1:0]   cfgOverhead,
  output logic               cmtValid,
  output logic [PC_W-1:0]    cmtPc,
  output logic [TIME_W-1:0]  cmtStart,
  output logic [TIME_W-1:0]  cmtFinish,
  output logic               doneValid,
  output logic [ID_W-1:0]    doneId
);

  stripe_ctrl_t ctrl;
  logic zeroChunks;
  logic lastChunk;
  logic timeUp;

  pc_stripe_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .zeroChunks (zeroChunks),
    .lastChunk  (lastChunk),
    .timeUp     (timeUp),
    .reqReady   (reqReady),
    .cmtValid   (cmtValid),
    .doneValid  (doneValid),
    .ctrl       (ctrl)
  );

  pc_stripe_dp #(
    .NUM_PCS     (NUM_PCS),
    .BURST_BYTES (BURST_BYTES),
    .BYTES_W     (BYTES_W),
    .ID_W        (ID_W),
    .CYC_W       (CYC_W),
    .TIME_W      (TIME_W)
  ) u_dp (
    .clk              (clk),
    .rst_n            (rst_n),
    .ctrl             (ctrl),
    .reqId            (reqId),
    .reqWrite         (reqWrite),
    .reqBytes         (reqBytes),
    .reqOrigBytes     (reqOrigBytes),
    .reqPace          (reqPace),
    .cfgServiceCycles (cfgServiceCycles),
    .cfgSwitchPenalty (cfgSwitchPenalty),
    .cfgOverhead      (cfgOverhead),
    .zeroChunks       (zeroChunks),
    .lastChunk        (lastChunk),
    .timeUp           (timeUp),
    .cmtPc            (cmtPc),
    .cmtStart         (cmtStart),
    .cmtFinish        (cmtFinish),
    .doneId           (doneId)
  );

endmodule

// File: rtl/pc_stripe_checker.sv
module pc_stripe_checker #(
  parameter int NUM_PCS = 8,
  parameter int PC_W    = 3,
  parameter int TIME_W  = 32
)(
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              cmtValid,
  input logic [PC_W-1:0]   cmtPc,
  input logic [TIME_W-1:0] cmtStart,
  input logic [TIME_W-1:0] cmtFinish,
  input logic              doneValid
);

  logic pastOk;
  logic [PC_W-1:0] prevPc;
  logic [PC_W-1:0] expPc;

  always_ff @(posedge clk) begin
    if (!rst_n) pastOk <= 1'b0;
    else        pastOk <= 1'b1;
  end

  always_ff @(posedge clk) prevPc <= cmtPc;
  assign expPc = (prevPc == PC_W'(NUM_PCS - 1)) ? '0 : prevPc + 1'b1;

  AST_PC_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (pastOk && cmtValid && $past(cmtValid)) |-> (cmtPc == expPc)); // R2

  AST_FINISH_NOT_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    cmtValid |-> (cmtFinish >= cmtStart)); // R4

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid); // R7

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady); // R8

  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> reqReady); // R8

  AST_CMT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cmtValid |-> (!reqReady && !doneValid)); // R9

endmodule

bind pc_stripe_sched pc_stripe_checker #(
  .NUM_PCS (NUM_PCS),
  .PC_W    (PC_W),
  .TIME_W  (TIME_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .cmtValid  (cmtValid),
  .cmtPc     (cmtPc),
  .cmtStart  (cmtStart),
  .cmtFinish (cmtFinish),
  .doneValid (doneValid)
);

// File: tb/pc_stripe_sched_test.sv
module pc_stripe_sched_test;

  localparam int CLK_PERIOD = 10;
  localparam int NPC   = 8;
  localparam int BURST = 256;
  localparam int NVEC  = 9;

  typedef struct packed {
    logic [19:0] bytes;
    logic [19:0] orig;
    logic        wr;
    logic [7:0]  pace;
  } vec_t;

  // bytes, orig, write, pace
  localparam vec_t VECS [NVEC] = '{
    '{20'd1024, 20'd0,   1'b1, 8'd0},  // 4 bursts, ch 0..3
    '{20'd300,  20'd0,   1'b0, 8'd0},  // 2 bursts, ch 4..5
    '{20'd0,    20'd600, 1'b0, 8'd0},  // zero-size read sized from orig (R3)
    '{20'd256,  20'd0,   1'b1, 8'd5},  // single paced burst
    '{20'd2048, 20'd0,   1'b0, 8'd1},  // 8 bursts, wraps, mixed turnaround
    '{20'd0,    20'd0,   1'b1, 8'd0},  // zero-length write
    '{20'd257,  20'd0,   1'b1, 8'd3},  // rounds up to 2
    '{20'd1,    20'd0,   1'b0, 8'd0},  // 1 byte
    '{20'd2304, 20'd0,   1'b1, 8'd0}   // 9 bursts, reuses a channel
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqId = '0;
  logic        reqWrite = 1'b0;
  logic [19:0] reqBytes = '0;
  logic [19:0] reqOrigBytes = '0;
  logic [7:0]  reqPace = '0;
  logic [7:0]  cfgServiceCycles = 8'd4;
  logic [7:0]  cfgSwitchPenalty = 8'd3;
  logic [7:0]  cfgOverhead = 8'd2;
  logic        cmtValid;
  logic [2:0]  cmtPc;
  logic [31:0] cmtStart;
  logic [31:0] cmtFinish;
  logic        doneValid;
  logic [7:0]  doneId;

  int checks = 0;
  int fails = 0;
  int ecount = 0;
  bit finished = 0;

  // reference model state
  int  availM [NPC];
  bit  usedM  [NPC];
  bit  dirM   [NPC];
  int  ptrM = 0;

  pc_stripe_sched uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .reqValid         (reqValid),
    .reqReady         (reqReady),
    .reqId            (reqId),
    .reqWrite         (reqWrite),
    .reqBytes         (reqBytes),
    .reqOrigBytes     (reqOrigBytes),
    .reqPace          (reqPace),
    .cfgServiceCycles (cfgServiceCycles),
    .cfgSwitchPenalty (cfgSwitchPenalty),
    .cfgOverhead      (cfgOverhead),
    .cmtValid         (cmtValid),
    .cmtPc            (cmtPc),
    .cmtStart         (cmtStart),
    .cmtFinish        (cmtFinish),
    .doneValid        (doneValid),
    .doneId           (doneId)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // mirror of the cycle counter defined in R6
  always @(posedge clk) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input int bytes, input int orig, input bit wr,
                         input int pace, input int id);
    int work, n, t0, pc, issue, st, fin, maxFin, expDone, guard;
    bit pen;
    string tag;
    work = (!wr && bytes == 0) ? orig : bytes;
    n = (work + BURST - 1) / BURST;
    @(negedge clk);
    check(reqReady == 1'b1, "R8", "ready when idle", reqReady, 1);
    reqValid = 1'b1; reqId = 8'(id); reqWrite = wr;
    reqBytes = 20'(bytes); reqOrigBytes = 20'(orig); reqPace = 8'(pace);
    t0 = ecount;
    @(negedge clk);
    reqValid = 1'b0;
    maxFin = t0 + int'(cfgOverhead);
    for (int k = 0; k < n; k++) begin
      pc = (ptrM + k) % NPC;
      issue = t0 + int'(cfgOverhead) + (k + 1) * pace;
      pen = usedM[pc] && (dirM[pc] != wr);
      st = ((issue > availM[pc]) ? issue : availM[pc]) + (pen ? int'(cfgSwitchPenalty) : 0);
      fin = st + int'(cfgServiceCycles);
      tag = pen ? "R5" : ((pace != 0) ? "R6" : ((!wr && bytes == 0) ? "R3" : "R4"));
      check(cmtValid == 1'b1, "R9", "commit valid", cmtValid, 1);
      if (k == 0) check(reqReady == 1'b0, "R8", "ready while busy", reqReady, 0);
      check(int'(cmtPc) == pc, "R2", "commit channel", cmtPc, pc);
      check(int'(cmtStart) == st, tag, "burst start", cmtStart, st);
      check(int'(cmtFinish) == fin, "R4", "burst finish", cmtFinish, fin);
      availM[pc] = fin; usedM[pc] = 1'b1; dirM[pc] = wr;
      if (fin > maxFin) maxFin = fin;
      @(negedge clk);
    end
    check(cmtValid == 1'b0, "R1", "burst count", cmtValid, 0);
    ptrM = (ptrM + n) % NPC;
    expDone = (maxFin > t0 + 1 + n) ? maxFin : t0 + 1 + n;
    guard = 0;
    while (!doneValid && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(ecount == expDone, "R7", "done cycle", ecount, expDone);
    check(int'(doneId) == id, "R7", "done id", doneId, id);
  endtask

  initial begin
    for (int i = 0; i < NPC; i++) begin
      availM[i] = 0; usedM[i] = 1'b0; dirM[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R8
    check(reqReady == 1'b1, "R8", "reset ready", reqReady, 1);
    check(doneValid == 1'b0, "R8", "reset done", doneValid, 0);
    check(cmtValid == 1'b0, "R8", "reset commit", cmtValid, 0);
    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int v = 0; v < NVEC; v++)
      run_txn(int'(VECS[v].bytes), int'(VECS[v].orig), VECS[v].wr,
              int'(VECS[v].pace), 16 + v);
    // R5: penalty cleared, direction flips cost nothing
    cfgSwitchPenalty = 8'd0;
    run_txn(1024, 0, 1'b0, 0, 40);
    run_txn(1024, 0, 1'b1, 2, 41);
    // R1: zero-length write retires on the overhead bound, pointer unchanged
    cfgOverhead = 8'd9;
    run_txn(0, 0, 1'b1, 0, 42);
    run_txn(512, 0, 1'b1, 0, 43);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule